// File: doc/BRIEF.md
# Programmable Watchdog With Output Steering

This block watches a host processor for signs of life. The host programs one control register with a 5-bit multiplier, a 2-bit resolution code and a steering bit. Every write of that register restarts a countdown of timebase ticks. If no new write arrives before the countdown runs out, the block sets a watchdog flag. It then raises one of two active-low outputs: an interrupt line, or a reset line.

The timebase is an input pulse `tick_i`, expected once per sixteenth of a second. The resolution code picks a step of 1, 4, 16 or 64 ticks (1/16 s, 1/4 s, 1 s, 4 s). The timeout is the multiplier times that step. A zero multiplier switches the watchdog off.

With interrupt steering, the interrupt stays low until the host reads the flags register. The countdown then stays stopped until the next control write. With reset steering, the reset line goes low for a fixed number of clock cycles. When the pulse ends, the countdown reloads from the stored control value and starts again.

The host port is a plain strobe interface with no back-pressure. A write or read takes effect in the cycle its strobe is sampled high. Read data is combinational from the address.

Top module: `wdg_top`

## Requirements
- R1: After reset, the control register is 0x00 and the watchdog flag is 0. Both `irq_n` and `wdog_rst_n` are high. Reading offset 0 returns 0x00 while `batt_low_i` is low.
- R2: Offset 7 is the control register. Bit 7 is the steering bit, bits 6:2 are the multiplier and bits 1:0 are the resolution code. A write to offset 7 reads back unchanged. Writes to offsets other than 0 and 7 are ignored, and those offsets read as 0x00.
- R3: The watchdog expires on the tick that completes the timeout. That tick is number `mult * 4^res`, counted after the last control write. The outputs and the flag change on the clock edge that samples that tick.
- R4: With a multiplier of 0, the watchdog never expires, however many ticks arrive.
- R5: Any write to offset 7 reloads the countdown from the newly written fields. Ticks that came before the write do not count.
- R6: With steering bit 0, expiry sets the flag (offset 0, bit 7) and drives `irq_n` low. `wdog_rst_n` stays high. A read of offset 0 returns the flag set and clears both the flag and the interrupt on the next edge. No further expiry occurs until offset 7 is written again.
- R7: With steering bit 1, expiry sets the flag and drives `wdog_rst_n` low for exactly `PULSE_CYC` clock cycles. `irq_n` stays high. After the pulse, the countdown restarts from the stored fields and expires again after the same number of ticks.
- R8: In the flags register, bit 4 mirrors `batt_low_i`. Bits 6, 5 and 3:0 always read 0.
- R9: If a read of offset 0 falls in the same cycle as an expiry, the flag and the interrupt are left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse, one per 1/16 s |
| batt_low_i | input | 1 | Battery-low status, shown in flags bit 4 |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of offset 0 clears the flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_n | output | 1 | Active-low interrupt on expiry with steering 0 |
| wdog_rst_n | output | 1 | Active-low reset pulse on expiry with steering 1 |

## Verification
The bench steps the timebase one tick at a time. It checks that nothing fires on the tick before the timeout and that the outputs fire on the final tick. A design with an off-by-one countdown, or with the resolution steps swapped, would fire one tick early or late, or at the wrong scale.

A write one tick before expiry must push the timeout out by a full period. A design that ignored reloads would fire early. The reset pulse width is counted cycle by cycle, and the reset-steered watchdog must fire a second time after the pulse. A wrong pulse counter or a missing restart would show up there.

A flags read that lands on the expiry cycle must not lose the flag. An interrupt that has been cleared must not come back while ticks keep arriving. A zero multiplier must stay silent.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int DATA_W = 8;
  localparam logic [3:0] OFS_FLAGS = 4'd0;
  localparam logic [3:0] OFS_CTL   = 4'd7;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdg_ctl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wf,
  input  logic              batt_low,
  output wdg_ctl_t          ctl,
  output logic              wr_ctl,
  output logic              flag_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  wdg_ctl_t ctl_q;

  assign wr_ctl  = bus_wr && (bus_addr == OFS_CTL);
  assign flag_rd = bus_rd && (bus_addr == OFS_FLAGS);
  assign ctl     = ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdg_ctl_t'(bus_wdata);
  end

  always_comb begin
    case (bus_addr)
      OFS_FLAGS: bus_rdata = {wf, 2'b00, batt_low, 4'b0000};
      OFS_CTL:   bus_rdata = DATA_W'(ctl_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R2: control register changes only through its own write
  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int RES_SHIFT = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [MULT_W-1:0] load_mult,
  input  logic [RES_W-1:0]  load_res,
  output logic              expire
);
  localparam int CNT_W = MULT_W + RES_SHIFT * ((1 << RES_W) - 1);

  logic [CNT_W-1:0] remain;
  logic             armed;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(load_mult) << (int'(load_res) * RES_SHIFT);
  assign expire   = armed && tick && !load && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      armed  <= |load_mult;
    end else if (expire) begin
      armed  <= 1'b0;
    end else if (armed && tick) begin
      remain <= remain - CNT_W'(1);
    end
  end

  // R4: an armed counter always has ticks left to count
  a_r4_armed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (remain != '0));
  // R4: loading a zero multiplier leaves the watchdog off
  a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_mult == '0) |=> !armed);
  // R3: one expiry per load
  a_r3_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/wdg_outctl.sv
module wdg_outctl #(
  parameter int PULSE_CYC = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic flag_rd,
  output logic wf,
  output logic irq_n,
  output logic wdog_rst_n,
  output logic restart
);
  localparam int PCW = $clog2(PULSE_CYC + 1);

  logic           wf_q;
  logic           irq_q;
  logic [PCW-1:0] pulse_cnt;
  logic           rst_active;

  assign rst_active = (pulse_cnt != '0);
  assign restart    = (pulse_cnt == PCW'(1));
  assign wf         = wf_q;
  assign irq_n      = ~irq_q;
  assign wdog_rst_n = ~rst_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wf_q      <= 1'b0;
      irq_q     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      if (expire)       wf_q <= 1'b1;
      else if (flag_rd) wf_q <= 1'b0;

      if (expire && !steer) irq_q <= 1'b1;
      else if (flag_rd)     irq_q <= 1'b0;

      if (expire && steer && !rst_active) pulse_cnt <= PCW'(PULSE_CYC);
      else if (rst_active)                pulse_cnt <= pulse_cnt - PCW'(1);
    end
  end

  // R6: interrupt is only active with the flag set
  a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> wf_q);
  // R6: flag read without a new expiry clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> !wf_q);
  // R7: pulse counter never exceeds its programmed length
  a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PCW'(PULSE_CYC));
  // R7: reset output is released right after the restart strobe
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !rst_active);
  // R9: expiry always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wf_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int RES_SHIFT = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       batt_low_i,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_n,
  output logic       wdog_rst_n
);
  wdg_ctl_t          ctl;
  wdg_ctl_t          wr_fields;
  logic              wr_ctl, flag_rd, wf, expire, restart, load;
  logic [MULT_W-1:0] ld_mult;
  logic [RES_W-1:0]  ld_res;

  assign wr_fields = wdg_ctl_t'(bus_wdata);
  assign load      = wr_ctl || restart;
  assign ld_mult   = wr_ctl ? wr_fields.mult : ctl.mult;
  assign ld_res    = wr_ctl ? wr_fields.res  : ctl.res;

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .wf(wf), .batt_low(batt_low_i),
    .ctl(ctl), .wr_ctl(wr_ctl), .flag_rd(flag_rd), .bus_rdata(bus_rdata)
  );

  wdg_timer #(.RES_SHIFT(RES_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .load(load),
    .load_mult(ld_mult), .load_res(ld_res), .expire(expire)
  );

  wdg_outctl #(.PULSE_CYC(PULSE_CYC)) u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(ctl.steer),
    .flag_rd(flag_rd), .wf(wf), .irq_n(irq_n), .wdog_rst_n(wdog_rst_n),
    .restart(restart)
  );

  // R1: outputs idle while the chip reset is held
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |=> (irq_n && wdog_rst_n));
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  localparam int PULSE = 8;

  logic       clk = 0, rst_n = 0, tick_i = 0, batt_low_i = 0;
  logic [3:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       irq_n, wdog_rst_n;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wdg_top #(.PULSE_CYC(PULSE)) u0 (.*);

  // {mult, res, steer, expected timeout in ticks}
  localparam logic [18:0] VEC [0:5] = '{
    {5'd3,  2'd0, 1'b0, 11'd3},
    {5'd2,  2'd1, 1'b0, 11'd8},
    {5'd1,  2'd2, 1'b1, 11'd16},
    {5'd5,  2'd0, 1'b1, 11'd5},
    {5'd1,  2'd3, 1'b0, 11'd64},
    {5'd31, 2'd1, 1'b0, 11'd124}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_flags(output logic [7:0] d);
    @(negedge clk); bus_addr = 0; bus_rd = 1; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic pulse_len(output int c);
    c = 0;
    while (!wdog_rst_n && c < 100) begin c++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog timeout");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(4'd7, d); check("R1 ctl", d, 8'h00);
    peek(4'd0, d); check("R1 flags", d, 8'h00);
    check("R1 irq_n", irq_n, 1); check("R1 rst_n", wdog_rst_n, 1);

    // vector table: R3 timeout, R6 irq, R7 reset pulse
    for (int v = 0; v < 6; v++) begin
      logic [4:0] m; logic [1:0] r; logic s; int t;
      {m, r, s} = VEC[v][18:11]; t = int'(VEC[v][10:0]);
      wr(4'd7, {s, m, r});
      ticks(t - 1);
      check("R3 before timeout", {irq_n, wdog_rst_n}, 2'b11);
      ticks(1);
      check("R3 fires", {irq_n, wdog_rst_n}, s ? 2'b10 : 2'b01);
      if (s) begin
        pulse_len(c); check("R7 pulse width", c, PULSE);
        wr(4'd7, 8'h00);
        rd_flags(d); check("R7 flag set", d, 8'h80);
      end else begin
        rd_flags(d); check("R6 flag set", d, 8'h80);
        check("R6 irq cleared", irq_n, 1);
      end
      peek(4'd0, d); check("R6 flag cleared", d, 8'h00);
    end

    // R2 layout and ignored offsets
    wr(4'd7, 8'hA6); peek(4'd7, d); check("R2 readback", d, 8'hA6);
    wr(4'd3, 8'hFF); peek(4'd3, d); check("R2 other offset", d, 8'h00);
    peek(4'd7, d); check("R2 ctl untouched", d, 8'hA6);

    // R4 zero multiplier
    wr(4'd7, 8'h03); ticks(100);
    check("R4 no expiry", {irq_n, wdog_rst_n}, 2'b11);
    peek(4'd0, d); check("R4 no flag", d, 8'h00);

    // R5 reload on write
    wr(4'd7, 8'h10); ticks(3);
    wr(4'd7, 8'h10); ticks(3);
    check("R5 reload delays", irq_n, 1);
    ticks(1); check("R5 fires after reload", irq_n, 0);
    rd_flags(d);
    ticks(20); check("R6 stays halted", irq_n, 1);
    peek(4'd0, d); check("R6 no new flag", d, 8'h00);

    // R7 restart after pulse
    wr(4'd7, 8'h88); ticks(2);
    check("R7 first fire", {irq_n, wdog_rst_n}, 2'b10);
    pulse_len(c); check("R7 first width", c, PULSE);
    ticks(1); check("R7 not yet", wdog_rst_n, 1);
    ticks(1); check("R7 restart fires", wdog_rst_n, 0);
    wr(4'd7, 8'h00); pulse_len(c); rd_flags(d);

    // R9 set beats clear
    wr(4'd7, 8'h04);
    @(negedge clk); tick_i = 1; bus_addr = 0; bus_rd = 1;
    @(negedge clk); tick_i = 0; bus_rd = 0;
    peek(4'd0, d); check("R9 flag kept", d, 8'h80);
    check("R9 irq kept", irq_n, 0);
    rd_flags(d); wr(4'd7, 8'h00);

    // R8 flag bits
    batt_low_i = 1; peek(4'd0, d); check("R8 batt bit", d, 8'h10);
    batt_low_i = 0; peek(4'd0, d); check("R8 batt clear", d, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule